// File: doc/BRIEF.md
# General-Purpose I/O Port Data Register

This block holds the output data and direction of a 16-bit general-purpose I/O port and decides, bit by bit, what the pin drives and what a bus read returns. A per-bit direction register marks each pin as input (0) or output (1). A per-bit function-select input hands a pin either to general I/O or to an alternate peripheral, whose output value and output-enable arrive as inputs to this block.

A bus write always lands in the selected register, even for bits whose pin is an input or is on its alternate function. A data-register read returns the stored bit for output-direction pins and the synchronized pin level for input-direction pins. Three bit positions are reserved and inert.

There are two resets. Power-on reset clears all state. Watchdog reset only clears the pin synchronizer, so the port configuration and output data survive it. Low-power modes need no handling, because the clock simply stops and the flops keep their contents.

Top module: `gpio_port_data`

## Requirements
- R1: While `por_n` is low at a clock edge, the data and direction registers clear to zero. After that edge, `rd_data`, `pin_out` and `pin_oe` are all zero, provided `pin_in` has been 0 and no bit is on its alternate function.
- R2: Bit positions 15, 3 and 1 (mask 0x800A) are reserved. They read as 0 from either register, ignore writes, and keep `pin_out` and `pin_oe` at 0 even when the bit is set to alternate function.
- R3: A write (`wr_en`=1 with `reg_sel`=0) stores `wr_data` into the data register on that clock edge, for every non-reserved bit. This holds whatever the bit's direction or function select.
- R4: With `reg_sel`=0, a bit whose direction bit is 1 reads back its stored data bit, whatever the pin level.
- R5: With `reg_sel`=0, a bit whose direction bit is 0 reads back the pin level, whatever the function select. A change on `pin_in` becomes visible in `rd_data` after exactly two clock edges.
- R6: For a bit on general function (`func_alt` bit 0), `pin_oe` equals the direction bit and `pin_out` equals the stored data bit. A written value therefore reaches the pin only when the direction bit is 1.
- R7: For a non-reserved bit on alternate function (`func_alt` bit 1), `pin_out` and `pin_oe` follow `alt_out` and `alt_oe`, and the data register has no effect on the pin.
- R8: Asserting `wdt_rst_n` low leaves the data and direction registers unchanged. Only the pin synchronizer is cleared.
- R9: A write with `reg_sel`=1 stores `wr_data` into the direction register. With `reg_sel`=1, `rd_data` returns the direction register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, synchronous, active low; clears all state |
| wdt_rst_n | input | 1 | Watchdog reset, synchronous, active low; clears only the synchronizer |
| wr_en | input | 1 | Bus write strobe, single cycle |
| reg_sel | input | 1 | Register select: 0 data, 1 direction |
| wr_data | input | 16 | Bus write data |
| rd_data | output | 16 | Bus read data, combinational |
| func_alt | input | 16 | Per-bit function select: 0 general I/O, 1 alternate |
| alt_out | input | 16 | Alternate-function output values |
| alt_oe | input | 16 | Alternate-function output enables |
| pin_in | input | 16 | Pin levels from the pads |
| pin_out | output | 16 | Value driven toward the pads |
| pin_oe | output | 16 | Output enable toward the pads |

## Verification
The direction register is loaded with a half-output pattern while the pins carry alternating bit patterns (0xAAAA, then 0x5555). Each read then has to pick the stored bit for some positions and the pin level for others, which separates a correct per-bit mux from one that selects per port or inverts the direction sense. A pin change is read one edge and two edges later, to pin the synchronizer depth at exactly two. An all-ones write while every pin is an input, followed by a switch to all outputs, shows that writes land regardless of direction and that the reserved bits stay inert. A mixed function-select pattern with distinct alternate values tells the alternate path apart from the general path. Watchdog and power-on resets are applied over loaded registers to show which state each reset reaches.

// File: rtl/gpio_port_pkg.sv
// Shared constants for the GPIO port data block.
// Assumes a 16-bit port with three inert bit positions.
package gpio_port_pkg;
    localparam int          PORT_W   = 16;
    localparam logic [15:0] RSV_BITS = 16'h800A;
endpackage

// File: rtl/gpio_sync.sv
// Two-flop synchronizer for the pin inputs.
// Assumes pin levels are asynchronous to clk and that bits are independent,
// so no bus-coherence guarantee is made across bits.
module gpio_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;
    logic [1:0]   age;

    // Purpose: shift the pin levels through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= d;
            stage2 <= stage1;
        end
    end

    assign q = stage2;

    // Purpose: count edges since reset so the delay check starts only once the pipe is full.
    always_ff @(posedge clk) begin
        if (!rst_n)            age <= 2'd0;
        else if (age != 2'd2)  age <= age + 2'd1;
    end

    // R5: the output is the input from exactly two edges earlier
    a_r5_two_edge_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd2) |-> (q == $past(d, 2)));
endmodule

// File: rtl/gpio_regs.sv
// Data and direction storage for the port.
// Assumes single-cycle writes. Only power-on reset clears these flops;
// watchdog reset is deliberately not an input here. Reserved bits are
// constant zero and hold no flop.
module gpio_regs #(
    parameter int          W   = 16,
    parameter logic [15:0] RSV = 16'h800A
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic         wr_en,
    input  logic         reg_sel,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] data_q,
    output logic [W-1:0] dir_q
);
    localparam logic [W-1:0] KEEP = ~RSV[W-1:0];

    logic wr_data_reg;
    logic wr_dir_reg;

    assign wr_data_reg = wr_en && !reg_sel;
    assign wr_dir_reg  = wr_en &&  reg_sel;

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (RSV[i]) begin : g_rsv
            assign data_q[i] = 1'b0;
            assign dir_q[i]  = 1'b0;
        end else begin : g_live
            // Purpose: one data bit and one direction bit, cleared only at power-on.
            always_ff @(posedge clk) begin
                if (!por_n) begin
                    data_q[i] <= 1'b0;
                    dir_q[i]  <= 1'b0;
                end else begin
                    if (wr_data_reg) data_q[i] <= wr_data[i];
                    if (wr_dir_reg)  dir_q[i]  <= wr_data[i];
                end
            end
        end
    end

    // R3: a data write lands on the next edge for every live bit
    a_r3_data_write: assert property (@(posedge clk) disable iff (!por_n)
        (wr_en && !reg_sel) |=> (data_q == ($past(wr_data) & KEEP)));

    // R9: a direction write lands on the next edge
    a_r9_dir_write: assert property (@(posedge clk) disable iff (!por_n)
        (wr_en && reg_sel) |=> (dir_q == ($past(wr_data) & KEEP)));

    // R8: without a write, nothing but power-on reset changes the registers
    a_r8_hold: assert property (@(posedge clk) disable iff (!por_n)
        !wr_en |=> ($stable(data_q) && $stable(dir_q)));
endmodule

// File: rtl/gpio_pin_mux.sv
// Per-bit read and pin-drive selection.
// Assumes data_q and dir_q already read zero on reserved bits; the mux
// forces reserved outputs to zero on its own as well.
module gpio_pin_mux #(
    parameter int          W   = 16,
    parameter logic [15:0] RSV = 16'h800A
) (
    input  logic         reg_sel,
    input  logic [W-1:0] data_q,
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] pin_sync,
    input  logic [W-1:0] func_alt,
    input  logic [W-1:0] alt_out,
    input  logic [W-1:0] alt_oe,
    output logic [W-1:0] rd_data,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (RSV[i]) begin : g_rsv
            assign rd_data[i] = 1'b0;
            assign pin_out[i] = 1'b0;
            assign pin_oe[i]  = 1'b0;
        end else begin : g_live
            // Purpose: pick the read source and the pin driver for one bit.
            always_comb begin
                if (reg_sel)       rd_data[i] = dir_q[i];
                else if (dir_q[i]) rd_data[i] = data_q[i];
                else               rd_data[i] = pin_sync[i];
                pin_out[i] = func_alt[i] ? alt_out[i] : data_q[i];
                pin_oe[i]  = func_alt[i] ? alt_oe[i]  : dir_q[i];
            end
        end
    end
endmodule

// File: rtl/gpio_port_data.sv
// Top of the GPIO port data block: synchronizer, storage and pin mux.
// Assumes synchronous active-low resets. The synchronizer is cleared by
// either reset; the registers are cleared by power-on reset only.
module gpio_port_data
    import gpio_port_pkg::*;
#(
    parameter int          W   = PORT_W,
    parameter logic [15:0] RSV = RSV_BITS
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic         wdt_rst_n,
    input  logic         wr_en,
    input  logic         reg_sel,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] rd_data,
    input  logic [W-1:0] func_alt,
    input  logic [W-1:0] alt_out,
    input  logic [W-1:0] alt_oe,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe
);
    localparam logic [W-1:0] LIVE = ~RSV[W-1:0];

    logic         sync_rst_n;
    logic [W-1:0] pin_sync;
    logic [W-1:0] data_q;
    logic [W-1:0] dir_q;

    assign sync_rst_n = por_n && wdt_rst_n;

    gpio_sync #(.W(W)) u_sync (
        .clk   (clk),
        .rst_n (sync_rst_n),
        .d     (pin_in),
        .q     (pin_sync)
    );

    gpio_regs #(.W(W), .RSV(RSV)) u_regs (
        .clk     (clk),
        .por_n   (por_n),
        .wr_en   (wr_en),
        .reg_sel (reg_sel),
        .wr_data (wr_data),
        .data_q  (data_q),
        .dir_q   (dir_q)
    );

    gpio_pin_mux #(.W(W), .RSV(RSV)) u_mux (
        .reg_sel  (reg_sel),
        .data_q   (data_q),
        .dir_q    (dir_q),
        .pin_sync (pin_sync),
        .func_alt (func_alt),
        .alt_out  (alt_out),
        .alt_oe   (alt_oe),
        .rd_data  (rd_data),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe)
    );

    // R2: reserved positions never drive or read as one
    a_r2_reserved_quiet: assert property (@(posedge clk) disable iff (!por_n)
        ((rd_data | pin_out | pin_oe) & RSV[W-1:0]) == '0);

    // R6: general-function bits enable their driver exactly per the direction register
    a_r6_general_oe: assert property (@(posedge clk) disable iff (!por_n)
        (((pin_oe ^ dir_q) & ~func_alt & LIVE) == '0));

    // R4: output-direction bits read back storage on a data read
    a_r4_output_readback: assert property (@(posedge clk) disable iff (!por_n)
        !reg_sel |-> (((rd_data ^ data_q) & dir_q & LIVE) == '0));
endmodule

// File: tb/test_gpio_port_data.sv
`timescale 1ns/100ps
module test_gpio_port_data;
    localparam logic [15:0] RSV  = 16'h800A;
    localparam logic [15:0] LIVE = ~RSV;

    typedef struct {
        string       tag;
        logic [15:0] rd;
        logic [15:0] out;
        logic [15:0] oe;
    } exp_t;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        wdt_rst_n = 1'b1;
    logic        wr_en = 1'b0;
    logic        reg_sel = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] func_alt = '0;
    logic [15:0] alt_out = '0;
    logic [15:0] alt_oe = '0;
    logic [15:0] pin_in = '0;
    logic [15:0] rd_data;
    logic [15:0] pin_out;
    logic [15:0] pin_oe;

    logic [15:0] m_data = '0;
    logic [15:0] m_dir  = '0;
    exp_t        sb[$];
    int          n_checks = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    gpio_port_data i_gpio_port_data (
        .clk       (clk),
        .por_n     (por_n),
        .wdt_rst_n (wdt_rst_n),
        .wr_en     (wr_en),
        .reg_sel   (reg_sel),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .func_alt  (func_alt),
        .alt_out   (alt_out),
        .alt_oe    (alt_oe),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic bus_write(input logic sel, input logic [15:0] v);
        reg_sel = sel;
        wr_data = v;
        wr_en   = 1'b1;
        tick();
        wr_en   = 1'b0;
        if (sel) m_dir  = v & LIVE;
        else     m_data = v & LIVE;
    endtask

    // Driver side: compute the expected view from the model and queue it.
    task automatic expect_view(input string tag, input logic [15:0] pin_seen);
        exp_t e;
        e.tag = tag;
        if (reg_sel) e.rd = m_dir & LIVE;
        else         e.rd = ((m_dir & m_data) | (~m_dir & pin_seen)) & LIVE;
        e.out = ((func_alt & alt_out) | (~func_alt & m_data)) & LIVE;
        e.oe  = ((func_alt & alt_oe)  | (~func_alt & m_dir))  & LIVE;
        sb.push_back(e);
        tick();
    endtask

    // Monitor: compare queued expectations at the falling edge.
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_checks += 3;
            if (rd_data !== e.rd) begin
                n_fail++;
                $display("FAIL %s rd_data actual=%h expected=%h", e.tag, rd_data, e.rd);
            end
            if (pin_out !== e.out) begin
                n_fail++;
                $display("FAIL %s pin_out actual=%h expected=%h", e.tag, pin_out, e.out);
            end
            if (pin_oe !== e.oe) begin
                n_fail++;
                $display("FAIL %s pin_oe actual=%h expected=%h", e.tag, pin_oe, e.oe);
            end
        end
    end

    initial begin
        #50000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: power-on reset clears everything
        repeat (3) tick();
        expect_view("R1 reset state", 16'h0000);
        por_n = 1'b1;
        tick();

        // R9: direction write and readback, reserved bits dropped (R2)
        bus_write(1'b1, 16'hFFFF);
        bus_write(1'b1, 16'h00FF);
        reg_sel = 1'b1;
        expect_view("R9 direction readback", 16'h0000);
        reg_sel = 1'b0;

        // R4/R5: mixed directions against an alternating pin pattern
        pin_in = 16'hAAAA;
        tick(); tick();
        bus_write(1'b0, 16'hFFFF);
        expect_view("R4 R5 mixed read, pins AAAA", 16'hAAAA);
        expect_view("R6 general drive follows direction", 16'hAAAA);

        // R5: two-edge synchronizer latency
        pin_in = 16'h5555;
        tick();
        expect_view("R5 one edge after pin change", 16'hAAAA);
        expect_view("R5 two edges after pin change", 16'h5555);

        // R4: stored bits ignore the pin level
        bus_write(1'b0, 16'h0F3C);
        expect_view("R4 stored value under pins 5555", 16'h5555);

        // R7: alternate function drives the pins; reads unaffected
        func_alt = 16'hFFFF;
        alt_out  = 16'h1234;
        alt_oe   = 16'hFFFF;
        expect_view("R7 R2 alternate all bits", 16'h5555);
        func_alt = 16'h0F0F;
        alt_out  = 16'hC3A5;
        alt_oe   = 16'h3C5A;
        expect_view("R7 alternate mixed select", 16'h5555);

        // R3: writes land while pins are inputs or alternate
        bus_write(1'b1, 16'h0000);
        bus_write(1'b0, 16'hFFFF);
        expect_view("R3 write while inputs, R5 read pins", 16'h5555);
        bus_write(1'b1, 16'hFFFF);
        expect_view("R3 R2 stored all-ones visible", 16'h5555);
        func_alt = 16'h0000;
        expect_view("R6 general all outputs", 16'h5555);

        // R8: watchdog reset keeps registers, clears synchronizer
        bus_write(1'b1, 16'hF0F0);
        bus_write(1'b0, 16'h3C3C);
        wdt_rst_n = 1'b0;
        repeat (3) tick();
        expect_view("R8 during watchdog reset", 16'h0000);
        wdt_rst_n = 1'b1;
        tick(); tick();
        expect_view("R8 after watchdog reset", 16'h5555);
        reg_sel = 1'b1;
        expect_view("R8 direction kept", 16'h5555);
        reg_sel = 1'b0;

        // R1: power-on reset over loaded state
        pin_in = 16'h0000;
        por_n  = 1'b0;
        tick();
        m_data = '0;
        m_dir  = '0;
        expect_view("R1 power-on clears loaded state", 16'h0000);
        por_n = 1'b1;
        tick();

        tick();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule